// File: doc/BRIEF.md
# Double-Buffered Multi-Channel DAC Input Register Bank

This block is the digital front end for a group of 16-bit converter channels that share one data bus. Each channel has a holding stage and an output stage. A host writes one channel at a time through that channel's own active-low select. When the host then raises the shared load input, every holding stage is copied into its output stage on the same clock edge, so all converter codes move together. A channel can also be set to direct mode. In direct mode its two stages act as one edge-triggered register that is clocked by the rising edge of the channel's own select.

All strobes are sampled on `clk`. The first stage of a buffered channel follows the bus on every clock while its select and the write strobe are both low. The value left in that stage when the strobe is released is the value kept. The output stage behaves the same way while `load` is high: it follows the first stage on every clock and freezes when `load` falls. The channel count is the parameter `NCH` (default 3). The word width is `DW` (default 16).

Top module: `dac_dbuf_bank`

## Requirements
- R1: While `rst_n` is low, and after it returns high, every channel's output code is zero and every first stage is zero.
- R2: For a channel with `direct_mode[i]`=0, a clock edge with `cs_n[i]`=0 and `wr_n`=0 loads `bus_data` into that channel's first stage. No output code changes as a result of that edge.
- R3: After `wr_n` returns high, a first stage keeps the last bus value it took, and later bus changes are ignored.
- R4: A buffered channel whose `cs_n[i]` is high keeps its first stage, even while `wr_n` is low.
- R5: A clock edge with `load`=1 copies the first stage into the output code of every buffered channel. All of those outputs change on the same edge.
- R6: While `load` is 0, the output code of a buffered channel holds its value.
- R7: When a write and `load` fall on the same edge, the output receives the first-stage contents from before that edge. The new bus value is visible only after a later load.
- R8: For a channel with `direct_mode[i]`=1, an edge where `cs_n[i]` is sampled high after being sampled low on the previous edge loads `bus_data` into both stages. The output shows it right after that edge.
- R9: A direct-mode channel ignores `load` and `wr_n`. Its output changes only on the event in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | DW | Shared data bus |
| cs_n | input | NCH | Per-channel select, active low |
| wr_n | input | 1 | Shared write strobe, active low |
| load | input | 1 | Shared commit strobe, active high |
| direct_mode | input | NCH | 1 = channel runs as a single edge-triggered register |
| dac_code | output | NCH*DW | Output codes, channel i in bits [i*DW +: DW] |

## Verification
The properties assume that all inputs are synchronous to `clk` and that `direct_mode` changes only while reset is held. A mode change in mid-run would create a select edge that no property accounts for. The stimulus drives every input on the falling clock edge and changes the mode only inside a reset pulse. Direct-mode select edges are produced as a low period of one or more clocks followed by a return high.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
  localparam int unsigned DEF_DW  = 16;
  localparam int unsigned DEF_NCH = 3;

  typedef enum logic {
    RANKS_TWO = 1'b0,
    RANKS_ONE = 1'b1
  } rank_mode_e;
endpackage

// File: rtl/dac_edge_rise.sv
module dac_edge_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl;
    rise  = lvl & ~lvl_q;
  end

  // resets to the idle (high) level of an active-low select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned DW = DEF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic          load,
  input  logic          direct,
  output logic [DW-1:0] stage1_q,
  output logic [DW-1:0] code_q
);
  rank_mode_e mode;
  logic       sel_rise;
  logic       s1_en, s2_en;
  logic [DW-1:0] s1_d, s2_d;

  dac_edge_rise u_sel_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (sel_n),
    .rise (sel_rise)
  );

  always_comb begin
    mode = direct ? RANKS_ONE : RANKS_TWO;
    s1_d = data;
    if (mode == RANKS_ONE) begin
      s1_en = sel_rise;
      s2_en = sel_rise;
      s2_d  = data;
    end else begin
      s1_en = ~sel_n & ~wr_n;
      s2_en = load;
      s2_d  = stage1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
    end else if (s1_en) begin
      stage1_q <= s1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (s2_en) begin
      code_q <= s2_d;
    end
  end
endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned NCH = DEF_NCH,
  parameter int unsigned DW  = DEF_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     bus_data,
  input  logic [NCH-1:0]    cs_n,
  input  logic              wr_n,
  input  logic              load,
  input  logic [NCH-1:0]    direct_mode,
  output logic [NCH*DW-1:0] dac_code
);
  localparam int unsigned BUSW = NCH * DW;

  logic [BUSW-1:0] stage1_bus;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_chan #(.DW(DW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .data    (bus_data),
      .sel_n   (cs_n[i]),
      .wr_n    (wr_n),
      .load    (load),
      .direct  (direct_mode[i]),
      .stage1_q(stage1_bus[i*DW +: DW]),
      .code_q  (dac_code[i*DW +: DW])
    );
  end
endmodule

// File: rtl/dac_dbuf_bank_chk.sv
module dac_dbuf_bank_chk #(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DW-1:0]     bus_data,
  input logic [NCH-1:0]    cs_n,
  input logic              wr_n,
  input logic              load,
  input logic [NCH-1:0]    direct_mode,
  input logic [NCH*DW-1:0] dac_code,
  input logic [NCH*DW-1:0] stage1_bus
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> (dac_code == '0 && stage1_bus == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R2
    wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!direct_mode[i] && !cs_n[i] && !wr_n) |=> stage1_bus[i*DW +: DW] == $past(bus_data));
    // R4
    unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!direct_mode[i] && cs_n[i]) |=> $stable(stage1_bus[i*DW +: DW]));
    // R6
    no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!direct_mode[i] && !load) |=> $stable(dac_code[i*DW +: DW]));
    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!direct_mode[i] && load) |=> dac_code[i*DW +: DW] == $past(stage1_bus[i*DW +: DW]));
    // R8
    direct_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && direct_mode[i] && $past(!cs_n[i]) && cs_n[i]) |=> dac_code[i*DW +: DW] == $past(bus_data));
    // R9
    direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && direct_mode[i] && !($past(!cs_n[i]) && cs_n[i])) |=> $stable(dac_code[i*DW +: DW]));
  end
endmodule

bind dac_dbuf_bank dac_dbuf_bank_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_data   (bus_data),
  .cs_n       (cs_n),
  .wr_n       (wr_n),
  .load       (load),
  .direct_mode(direct_mode),
  .dac_code   (dac_code),
  .stage1_bus (stage1_bus)
);

// File: tb/tb_dac_dbuf_bank.sv
`timescale 1ns/1ps
module tb_dac_dbuf_bank;
  localparam int NCH = 3;
  localparam int DW  = 16;
  localparam int NV  = 11;
  localparam int VW  = 3 + 1 + 1 + DW + 3*DW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DW-1:0]     bus_data;
  logic [NCH-1:0]    cs_n;
  logic              wr_n;
  logic              load;
  logic [NCH-1:0]    direct_mode;
  logic [NCH*DW-1:0] dac_code;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dac_dbuf_bank #(.NCH(NCH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .cs_n(cs_n),
    .wr_n(wr_n), .load(load), .direct_mode(direct_mode), .dac_code(dac_code)
  );

  // {cs_n, wr_n, load, data, exp ch2, exp ch1, exp ch0}: codes after the edge
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b110, 1'b0, 1'b0, 16'h1111, 16'h0000, 16'h0000, 16'h0000}, // R2
    {3'b110, 1'b1, 1'b0, 16'h2222, 16'h0000, 16'h0000, 16'h0000}, // R3
    {3'b101, 1'b0, 1'b0, 16'h3333, 16'h0000, 16'h0000, 16'h0000}, // R2
    {3'b011, 1'b0, 1'b0, 16'h4444, 16'h0000, 16'h0000, 16'h0000}, // R2
    {3'b011, 1'b0, 1'b0, 16'h4545, 16'h0000, 16'h0000, 16'h0000}, // R3
    {3'b111, 1'b0, 1'b0, 16'h9999, 16'h0000, 16'h0000, 16'h0000}, // R4
    {3'b111, 1'b1, 1'b1, 16'h0000, 16'h4545, 16'h3333, 16'h1111}, // R5
    {3'b110, 1'b0, 1'b0, 16'h5555, 16'h4545, 16'h3333, 16'h1111}, // R6
    {3'b110, 1'b0, 1'b1, 16'hAAAA, 16'h4545, 16'h3333, 16'h5555}, // R7
    {3'b111, 1'b1, 1'b1, 16'hFFFF, 16'h4545, 16'h3333, 16'hAAAA}, // R7
    {3'b111, 1'b1, 1'b0, 16'hFFFF, 16'h4545, 16'h3333, 16'hAAAA}  // R6
  };

  task automatic chk(input string req, input int ch, input logic [DW-1:0] exp);
    checks++;
    if (dac_code[ch*DW +: DW] !== exp) begin
      errors++;
      $display("FAIL %s ch%0d actual %h expected %h", req, ch, dac_code[ch*DW +: DW], exp);
    end
  endtask

  task automatic step(input logic [NCH-1:0] c, input logic w, input logic l, input logic [DW-1:0] d);
    cs_n = c; wr_n = w; load = l; bus_data = d;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [NCH-1:0] m);
    rst_n = 1'b0; direct_mode = m;
    cs_n = '1; wr_n = 1'b1; load = 1'b0; bus_data = '0;
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCH; c++) chk("R1", c, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; direct_mode = '0; cs_n = '1; wr_n = 1'b1; load = 1'b0; bus_data = '0;
    @(negedge clk);
    do_reset(3'b000);
    for (int c = 0; c < NCH; c++) chk("R1", c, '0);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e = VEC[v];
      step(e[VW-1 -: 3], e[VW-4], e[VW-5], e[VW-6 -: DW]);
      for (int c = 0; c < NCH; c++)
        chk($sformatf("R%0s v%0d", "2-7", v), c, e[c*DW +: DW]);
    end

    // R1: mid-run reset clears outputs and first stages
    do_reset(3'b000);
    step(3'b111, 1'b1, 1'b1, 16'h0000);
    for (int c = 0; c < NCH; c++) chk("R1", c, '0);

    // R8 / R9: channel 1 direct, others buffered
    do_reset(3'b010);
    step(3'b111, 1'b0, 1'b0, 16'h7777);            // write strobe, no select
    step(3'b101, 1'b1, 1'b0, 16'h1234);            // select low
    chk("R8", 1, 16'h0000);
    step(3'b101, 1'b0, 1'b1, 16'h1235);            // still low, load: R9
    chk("R9", 1, 16'h0000);
    step(3'b111, 1'b1, 1'b0, 16'h5678);            // rising select
    chk("R8", 1, 16'h5678);
    step(3'b110, 1'b0, 1'b0, 16'hBEEF);            // write ch0
    step(3'b111, 1'b1, 1'b1, 16'h0000);            // load
    chk("R9", 1, 16'h5678);
    chk("R5", 0, 16'hBEEF);
    chk("R5", 2, 16'h0000);
    step(3'b111, 1'b1, 1'b0, 16'h0000);
    chk("R9", 1, 16'h5678);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule